// File: doc/BRIEF.md
# Vectored Interrupt Pending Controller

This block gathers up to 32 level-sensitive interrupt request lines from peripherals and presents them to a processor on two active-low request outputs: a normal line (`irq_n`) and a fast line (`fiq_n`). Each request is passed through a two-flop synchroniser. It then sets a bit in a raw pending register. That bit stays set, whatever its mask bit, until software clears it. A per-source mode bit sends a source either to the normal path or to the fast path. A per-source mask bit keeps a source away from both outputs.

For the normal path, a second register holds a one-hot record of the winning source. When this register is empty, it loads the lowest-numbered pending source that is unmasked and in normal mode. Lower index means higher priority. The record then stays in place until software clears it, even if a higher-priority request arrives later. The normal output is low while the record is non-zero. The fast output is low while any unmasked fast-mode source is pending.

After servicing a source, software clears its raw pending bit first and then its winner bit. Both pending registers are write-one-to-clear. Software reads and writes all registers through a simple 32-bit register port. A write takes effect at the clock edge, and read data is returned in the same cycle.

Top module: `irq_pend_ctrl`

## Requirements
- R1: After reset the mask register reads all ones for every implemented source, and the mode, raw pending and winner registers read zero. Both `irq_n` and `fiq_n` are high.
- R2: A request line held high sets its bit in the raw pending register (offset 0x00) within four clock cycles, and this happens even when the source is masked.
- R3: Writing a 1 to a bit at offset 0x00 clears that raw pending bit, unless the request is still high, in which case the bit stays set. Writing a 0 leaves the bit unchanged.
- R4: The winner register (offset 0x10) has at most one bit set. When it is empty, it loads the lowest-index source that is raw-pending, unmasked, and in normal mode (mode bit 0).
- R5: Once a winner bit is set, it holds until software writes a 1 to it at offset 0x10. It holds even when its request drops, when its raw pending bit is cleared, or when a higher-priority source becomes pending.
- R6: `irq_n` is low exactly when the winner register is non-zero.
- R7: A source whose mode bit (offset 0x04) is 1 never enters the winner register. `fiq_n` is low while any such source is raw-pending and unmasked.
- R8: A source whose mask bit (offset 0x08, 1 = blocked) is set cannot load the winner register and cannot drive `fiq_n` low.
- R9: The mode and mask registers read back the last value written. A read from any other offset returns zero, and a write to any other offset changes no register.
- R10: After the winner bit is cleared, the next-highest-priority eligible pending source loads into the winner register on the following clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | NUM_SRC | Asynchronous level-sensitive peripheral requests |
| reg_addr | input | 8 | Register byte offset |
| reg_wr | input | 1 | Register write strobe for the current cycle |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |
| irq_n | output | 1 | Normal interrupt request to the processor, active low |
| fiq_n | output | 1 | Fast interrupt request to the processor, active low |

## Verification
The bench builds the block with its default of 32 sources. At that size, source 31, the top bit of every register, can be exercised as a fast source beside low- and mid-index normal sources. Three sources are made pending together so that the priority order is seen as each winner is cleared in turn. Requests are held high across clear writes to show that a level request sets its bit again. A write to an unused offset is followed by a read-back of the mask, to show that the write had no effect.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;

    localparam int WORD_W = 32;
    localparam int ADDR_W = 8;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [ADDR_W-1:0] {
        OFS_SRC  = 8'h00,
        OFS_MODE = 8'h04,
        OFS_MASK = 8'h08,
        OFS_WIN  = 8'h10
    } reg_ofs_e;

    typedef struct packed {
        word_t src;
        word_t mode;
        word_t mask;
        word_t win;
    } reg_state_t;

    typedef struct packed {
        logic  wr_src;
        logic  wr_mode;
        logic  wr_mask;
        logic  wr_win;
    } wr_dec_t;

    function automatic word_t lowest_onehot(word_t x);
        return x & (~x + word_t'(1));
    endfunction

    function automatic wr_dec_t decode_wr(logic wr, addr_t a);
        wr_dec_t d;
        d.wr_src  = wr && (a == OFS_SRC);
        d.wr_mode = wr && (a == OFS_MODE);
        d.wr_mask = wr && (a == OFS_MASK);
        d.wr_win  = wr && (a == OFS_WIN);
        return d;
    endfunction

endpackage

// File: rtl/irq_req_sync.sv
module irq_req_sync
    import irq_pend_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] req_i,
    output word_t              req_s
);

    logic [NUM_SRC-1:0] stage1;
    logic [NUM_SRC-1:0] stage2;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_sync
        always_ff @(posedge clk) begin
            if (rst) begin
                stage1[g] <= 1'b0;
                stage2[g] <= 1'b0;
            end else begin
                stage1[g] <= req_i[g];
                stage2[g] <= stage1[g];
            end
        end
    end

    assign req_s = WORD_W'(stage2);

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
    import irq_pend_pkg::*;
(
    input  word_t src,
    input  word_t mode,
    input  word_t mask,
    output word_t pick_onehot,
    output logic  fast_any
);

    word_t norm_elig;
    word_t fast_elig;

    always_comb begin
        norm_elig   = src & ~mask & ~mode;
        fast_elig   = src & ~mask & mode;
        pick_onehot = lowest_onehot(norm_elig);
        fast_any    = |fast_elig;
    end

endmodule

// File: rtl/irq_reg_bank.sv
module irq_reg_bank
    import irq_pend_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input  logic       clk,
    input  logic       rst,
    input  word_t      req_s,
    input  word_t      pick_onehot,
    input  addr_t      reg_addr,
    input  logic       reg_wr,
    input  word_t      reg_wdata,
    output word_t      reg_rdata,
    output reg_state_t st
);

    localparam word_t VALID = {WORD_W{1'b1}} >> (WORD_W - NUM_SRC);

    wr_dec_t dec;
    word_t   clr_src;
    word_t   clr_win;
    word_t   win_kept;
    word_t   elig_now;

    always_comb begin
        dec      = decode_wr(reg_wr, reg_addr);
        clr_src  = dec.wr_src ? reg_wdata : '0;
        clr_win  = dec.wr_win ? reg_wdata : '0;
        win_kept = st.win & ~clr_win;
        elig_now = st.src & ~st.mask & ~st.mode;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st.src  <= '0;
            st.mode <= '0;
            st.mask <= VALID;
            st.win  <= '0;
        end else begin
            st.src <= ((st.src & ~clr_src) | req_s) & VALID;
            if (dec.wr_mode) st.mode <= reg_wdata & VALID;
            if (dec.wr_mask) st.mask <= reg_wdata & VALID;
            st.win <= (win_kept != '0) ? win_kept : (pick_onehot & VALID);
        end
    end

    always_comb begin
        unique case (reg_addr)
            OFS_SRC:  reg_rdata = st.src;
            OFS_MODE: reg_rdata = st.mode;
            OFS_MASK: reg_rdata = st.mask;
            OFS_WIN:  reg_rdata = st.win;
            default:  reg_rdata = '0;
        endcase
    end

    // R4: winner register never holds more than one source
    assert_win_onehot_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(st.win));

    // R5: a held winner survives every cycle without a clear write
    assert_win_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (st.win != '0) && !dec.wr_win |=> st.win == $past(st.win));

    // R8: a newly loaded winner was eligible (unmasked, normal mode) when loaded
    assert_win_eligible_R8: assert property (@(posedge clk) disable iff (rst)
        (st.win == '0) |=> ((st.win & ~$past(elig_now)) == '0));

    // R2: a synchronised request always lands in raw pending
    assert_src_set_R2: assert property (@(posedge clk) disable iff (rst)
        (req_s != '0) |=> ((st.src & $past(req_s & VALID)) == $past(req_s & VALID)));

    // R3: a clear write removes bits whose request is low
    assert_src_w1c_R3: assert property (@(posedge clk) disable iff (rst)
        dec.wr_src |=> ((st.src & $past(clr_src & ~req_s)) == '0));

endmodule

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl
    import irq_pend_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] req_i,
    input  logic [7:0]         reg_addr,
    input  logic               reg_wr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic               irq_n,
    output logic               fiq_n
);

    word_t      req_s;
    word_t      pick_onehot;
    logic       fast_any;
    reg_state_t st;

    irq_req_sync #(.NUM_SRC(NUM_SRC)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .req_i (req_i),
        .req_s (req_s)
    );

    irq_prio_pick u_pick (
        .src         (st.src),
        .mode        (st.mode),
        .mask        (st.mask),
        .pick_onehot (pick_onehot),
        .fast_any    (fast_any)
    );

    irq_reg_bank #(.NUM_SRC(NUM_SRC)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .req_s       (req_s),
        .pick_onehot (pick_onehot),
        .reg_addr    (reg_addr),
        .reg_wr      (reg_wr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .st          (st)
    );

    assign irq_n = ~(|st.win);
    assign fiq_n = ~fast_any;

    // R7: a fast-mode source never occupies the winner register when loaded
    assert_fast_not_win_R7: assert property (@(posedge clk) disable iff (rst)
        (st.win == '0) |=> ((st.win & $past(st.mode)) == '0));

endmodule

// File: tb/irq_pend_ctrl_tb.sv
module irq_pend_ctrl_tb;

    localparam int NSRC = 32;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NSRC-1:0] req_i = '0;
    logic [7:0]      reg_addr = '0;
    logic            reg_wr = 1'b0;
    logic [31:0]     reg_wdata = '0;
    logic [31:0]     reg_rdata;
    logic            irq_n;
    logic            fiq_n;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    irq_pend_ctrl #(.NUM_SRC(NSRC)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .req_i     (req_i),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_n     (irq_n),
        .fiq_n     (fiq_n)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(posedge clk);
        #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(8'h00, v); check("R1 src", v, 32'h0);
        rd(8'h04, v); check("R1 mode", v, 32'h0);
        rd(8'h08, v); check("R1 mask", v, 32'hFFFF_FFFF);
        rd(8'h10, v); check("R1 win", v, 32'h0);
        check("R1 irq_n", {31'b0, irq_n}, 32'h1);
        check("R1 fiq_n", {31'b0, fiq_n}, 32'h1);
    endtask

    task automatic t_masked_capture();
        logic [31:0] v;
        @(negedge clk); req_i[5] = 1'b1;
        tick(4);
        rd(8'h00, v); check("R2 masked capture", v, 32'h20);
        rd(8'h10, v); check("R8 masked no win", v, 32'h0);
        check("R8 irq_n masked", {31'b0, irq_n}, 32'h1);
    endtask

    task automatic t_priority();
        logic [31:0] v;
        wr(8'h08, ~32'h0000_0228);
        tick(2);
        rd(8'h10, v); check("R4 win first", v, 32'h20);
        check("R6 irq_n low", {31'b0, irq_n}, 32'h0);
        @(negedge clk); req_i[3] = 1'b1; req_i[9] = 1'b1;
        tick(4);
        rd(8'h00, v); check("R2 three pending", v, 32'h228);
        rd(8'h10, v); check("R5 no preempt", v, 32'h20);
        wr(8'h00, 32'h0);
        rd(8'h00, v); check("R3 write zero", v, 32'h228);
        wr(8'h00, 32'h08);
        tick(1);
        rd(8'h00, v); check("R3 level reset", v, 32'h228);
        @(negedge clk); req_i = '0;
        tick(4);
        wr(8'h00, 32'h20);
        rd(8'h00, v); check("R3 clear bit5", v, 32'h208);
        rd(8'h10, v); check("R5 hold after src clr", v, 32'h20);
        wr(8'h10, 32'h20);
        tick(1);
        rd(8'h10, v); check("R10 next winner", v, 32'h08);
        wr(8'h00, 32'h08);
        wr(8'h10, 32'h08);
        tick(1);
        rd(8'h10, v); check("R10 third winner", v, 32'h200);
        wr(8'h00, 32'h200);
        wr(8'h10, 32'h200);
        tick(2);
        rd(8'h10, v); check("R4 empty", v, 32'h0);
        check("R6 irq_n high", {31'b0, irq_n}, 32'h1);
    endtask

    task automatic t_fast();
        logic [31:0] v;
        wr(8'h04, 32'h8000_0000);
        wr(8'h08, 32'h7FFF_FFFF);
        rd(8'h04, v); check("R9 mode readback", v, 32'h8000_0000);
        rd(8'h08, v); check("R9 mask readback", v, 32'h7FFF_FFFF);
        @(negedge clk); req_i[31] = 1'b1;
        tick(4);
        check("R7 fiq_n low", {31'b0, fiq_n}, 32'h0);
        rd(8'h10, v); check("R7 fast not win", v, 32'h0);
        check("R7 irq_n high", {31'b0, irq_n}, 32'h1);
        wr(8'h08, 32'hFFFF_FFFF);
        tick(1);
        check("R8 fast masked", {31'b0, fiq_n}, 32'h1);
        wr(8'h08, 32'h7FFF_FFFF);
        tick(1);
        check("R7 fiq_n again", {31'b0, fiq_n}, 32'h0);
        @(negedge clk); req_i[31] = 1'b0;
        tick(4);
        wr(8'h00, 32'h8000_0000);
        tick(1);
        check("R7 fiq_n released", {31'b0, fiq_n}, 32'h1);
        rd(8'h00, v); check("R3 fast cleared", v, 32'h0);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        wr(8'h0C, 32'h0000_0000);
        rd(8'h0C, v); check("R9 unmapped read", v, 32'h0);
        rd(8'h08, v); check("R9 mask untouched", v, 32'h7FFF_FFFF);
        rd(8'h04, v); check("R9 mode untouched", v, 32'h8000_0000);
    endtask

    initial begin
        tick(3);
        @(negedge clk); rst = 1'b0;
        tick(1);
        t_reset();
        t_masked_capture();
        t_priority();
        t_fast();
        t_unmapped();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule